// File: doc/BRIEF.md
# Received Pause Timer for an Ethernet Transmit Path

This block turns received flow-control pause requests into a transmit stop. An upstream receive parser, which has already checked the frame and its CRC, hands over one pause request per frame: a valid strobe and the 16-bit pause time. A non-zero pause time raises a transmit-off flag and loads a countdown counted in pause quanta. The transmitter gate then closes. It closes at once if no packet is on the wire; otherwise it closes when the packet in flight finishes. A pause time of zero is an explicit resume: it clears the flag straight away and is added to a saturating resume tally.

One pause quantum is 512 bit times. A prescaler that emits one tick every `TICKS_PER_QUANTUM` clock cycles stands in for it. At 64 bits per cycle the default of 8 matches the quantum. The request input is a valid/ready stream. `pause_ready` is low while in reset and through the first edge after reset. After that it stays high, so every request is taken in the cycle it is offered and none is held back or dropped. A request counts as accepted only in a cycle where both `pause_valid` and `pause_ready` are high. The transmitter reads `tx_enable` before it starts a packet. It raises `tx_busy` for as long as a packet is in flight.

Top module: `pause_rx_timer`

## Requirements
- R1: While reset is asserted, `xoff_status`, `tx_enable`, `tx_halted`, `pause_ready` and `resume_count` are all 0. On the first clock edge after release, `pause_ready` and `tx_enable` go to 1.
- R2: An accepted request with a non-zero pause time sets `xoff_status` on that clock edge, which drops `tx_enable` in the same cycle.
- R3: After an accepted request with non-zero time N, and with no further request, `xoff_status` stays high for exactly N × `TICKS_PER_QUANTUM` cycles and then clears by itself.
- R4: `tx_halted` rises one edge after `xoff_status` is set if `tx_busy` is low in that cycle. If `tx_busy` is high, `tx_halted` waits and rises on the first edge at which `tx_busy` is sampled low. It never rises while the packet is still busy.
- R5: An accepted request with pause time 0 clears `xoff_status` on its edge. `tx_halted` then falls one edge later.
- R6: Each accepted zero-time request adds 1 to `resume_count`, whether or not the block is paused. A zero-time request that arrives while not paused leaves `xoff_status` at 0.
- R7: `resume_count` (`RESUME_W` bits) holds at its all-ones value and does not wrap.
- R8: A non-zero request accepted while paused restarts the countdown. The pause then ends exactly N_new × `TICKS_PER_QUANTUM` cycles after the edge that accepted the new request.
- R9: `tx_enable` is high exactly when reset is over and `xoff_status` is low.
- R10: `pause_ready` stays high in every cycle after the first edge following reset. Requests are therefore never back-pressured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pause_valid | input | 1 | A validated pause request is offered |
| pause_ready | output | 1 | Request accepted when high together with valid |
| pause_time | input | QUANTA_W | Requested pause length in quanta; 0 means resume |
| tx_busy | input | 1 | A packet is currently being transmitted |
| tx_enable | output | 1 | Transmitter may start a new packet |
| tx_halted | output | 1 | Transmitter is stopped and idle due to pause |
| xoff_status | output | 1 | Transmit-off flag |
| resume_count | output | RESUME_W | Saturating count of zero-time requests |

## Verification
The hardest case to reach from the ports is a new request that lands in the middle of a running countdown, part way through a quantum. The stimulus records the cycle on which each request is accepted and places the second request well before the first pause would end. It then checks that the pause ends a full new countdown after the second acceptance, so the countdown and the prescaler must both restart. The other hard case is a pause that arrives while a packet is busy. The bench holds `tx_busy` high across the acceptance and over several further cycles before releasing it. It then checks that `tx_halted` rises on the edge that follows the release.

// File: rtl/pause_pkg.sv
package pause_pkg;

  // Transmit gate: open, waiting for the packet in flight to end, or shut.
  typedef enum logic [1:0] {
    GATE_OPEN  = 2'd0,
    GATE_DRAIN = 2'd1,
    GATE_SHUT  = 2'd2
  } gate_state_e;

  // Width of a prescaler counter for a given ticks-per-quantum value.
  function automatic int unsigned presc_width(input int unsigned ticks);
    return (ticks > 1) ? $clog2(ticks) : 1;
  endfunction

endpackage

// File: rtl/pause_quanta_prescaler.sv
module pause_quanta_prescaler #(
  parameter int unsigned TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  import pause_pkg::*;

  localparam int unsigned CW = presc_width(TICKS);

  generate
    if (TICKS <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
          cnt_q <= '0;
        end else if (cnt_q == LAST) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign tick = run && (cnt_q == LAST);

      a_r3_presc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    end
  endgenerate

endmodule

// File: rtl/pause_countdown.sv
module pause_countdown #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expire
);

  logic [W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (tick && remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign expire = !load && tick && (remain_q == W'(1));

  // R8: a load always takes the new value, whatever was left
  a_r8_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> remain_q == $past(load_val));

  // R3: without a load the count never climbs
  a_r3_no_climb: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> remain_q <= $past(remain_q));

endmodule

// File: rtl/pause_resume_counter.sv
module pause_resume_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (bump && cnt_q != TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count = cnt_q;

  a_r7_hold_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == TOP |=> cnt_q == TOP);

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/pause_rx_timer.sv
module pause_rx_timer #(
  parameter int unsigned QUANTA_W          = 16,
  parameter int unsigned TICKS_PER_QUANTUM = 8,
  parameter int unsigned RESUME_W          = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pause_valid,
  output logic                pause_ready,
  input  logic [QUANTA_W-1:0] pause_time,
  input  logic                tx_busy,
  output logic                tx_enable,
  output logic                tx_halted,
  output logic                xoff_status,
  output logic [RESUME_W-1:0] resume_count
);
  import pause_pkg::*;

  logic        ready_q;
  logic        xoff_q;
  logic        accept;
  logic        is_resume;
  logic        tick;
  logic        expire;
  gate_state_e gate_q;
  gate_state_e gate_d;

  assign accept    = pause_valid && ready_q;
  assign is_resume = (pause_time == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
    end
  end

  pause_quanta_prescaler #(
    .TICKS(TICKS_PER_QUANTUM)
  ) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (xoff_q),
    .restart(accept),
    .tick   (tick)
  );

  pause_countdown #(
    .W(QUANTA_W)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .load_val(pause_time),
    .tick    (tick),
    .expire  (expire)
  );

  pause_resume_counter #(
    .W(RESUME_W)
  ) u_resume (
    .clk  (clk),
    .rst_n(rst_n),
    .bump (accept && is_resume),
    .count(resume_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xoff_q <= 1'b0;
    end else if (accept) begin
      xoff_q <= !is_resume;
    end else if (expire) begin
      xoff_q <= 1'b0;
    end
  end

  always_comb begin
    gate_d = gate_q;
    unique case (gate_q)
      GATE_OPEN:  if (xoff_q) gate_d = tx_busy ? GATE_DRAIN : GATE_SHUT;
      GATE_DRAIN: if (!xoff_q) gate_d = GATE_OPEN;
                  else if (!tx_busy) gate_d = GATE_SHUT;
      GATE_SHUT:  if (!xoff_q) gate_d = GATE_OPEN;
      default:    gate_d = GATE_OPEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= GATE_OPEN;
    end else begin
      gate_q <= gate_d;
    end
  end

  assign pause_ready = ready_q;
  assign xoff_status = xoff_q;
  assign tx_enable   = ready_q && !xoff_q;
  assign tx_halted   = (gate_q == GATE_SHUT);

  a_r2_set_off: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_resume) |=> xoff_status);

  a_r5_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_resume) |=> !xoff_status);

  a_r4_shut_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_halted) |-> !$past(tx_busy));

  a_r9_enable_excl: assert property (@(posedge clk) disable iff (!rst_n)
    tx_enable |-> !xoff_status);

  a_r10_ready_stays: assert property (@(posedge clk) disable iff (!rst_n)
    pause_ready |=> pause_ready);

endmodule

// File: tb/test_pause_rx_timer.sv
module test_pause_rx_timer;

  localparam int TPQ = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pv = 1'b0;
  logic [15:0] pt = '0;
  logic        busy = 1'b0;
  logic        ready, tx_en, halted, xoff;
  logic [7:0]  rcnt;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int run_len = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pause_rx_timer #(
    .QUANTA_W(16), .TICKS_PER_QUANTUM(TPQ), .RESUME_W(8)
  ) i_pause_rx_timer (
    .clk(clk), .rst_n(rst_n), .pause_valid(pv), .pause_ready(ready),
    .pause_time(pt), .tx_busy(busy), .tx_enable(tx_en), .tx_halted(halted),
    .xoff_status(xoff), .resume_count(rcnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: offer one request, return the cycle stamp of its accepting edge.
  task automatic send(input logic [15:0] t, output int acc);
    @(negedge clk);
    pv = 1'b1;
    pt = t;
    @(posedge clk);
    #1;
    acc = cyc;
    pv = 1'b0;
  endtask

  // Monitor: measure each xoff episode, compare with the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (xoff) begin
        run_len++;
      end else if (run_len > 0) begin
        if (exp_q.size() == 0) begin
          chk("R3 unexpected episode", run_len, 0);
        end else begin
          chk("R3/R8 pause length", run_len, exp_q.pop_front());
        end
        run_len = 0;
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    int a1, a2;
    repeat (3) @(negedge clk);
    chk("R1 xoff in reset", int'(xoff), 0);
    chk("R1 tx_enable in reset", int'(tx_en), 0);
    chk("R1 halted in reset", int'(halted), 0);
    chk("R1 ready in reset", int'(ready), 0);
    chk("R1 count in reset", int'(rcnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(ready), 1);
    chk("R9 tx_enable after reset", int'(tx_en), 1);

    // Immediate stop, idle transmitter
    send(16'd5, a1);
    exp_q.push_back(5 * TPQ);
    @(negedge clk);
    chk("R2 xoff set", int'(xoff), 1);
    chk("R9 tx_enable low", int'(tx_en), 0);
    chk("R4 halted not yet", int'(halted), 0);
    @(negedge clk);
    chk("R4 halted when idle", int'(halted), 1);
    wait (xoff == 1'b0);
    @(negedge clk);
    chk("R9 tx_enable back", int'(tx_en), 1);
    @(negedge clk);
    chk("R4 halted released", int'(halted), 0);

    // Deferred stop behind a busy packet
    @(negedge clk);
    busy = 1'b1;
    send(16'd3, a1);
    exp_q.push_back(3 * TPQ);
    repeat (4) begin
      @(negedge clk);
      chk("R4 no halt while busy", int'(halted), 0);
    end
    busy = 1'b0;
    @(negedge clk);
    chk("R4 halt after packet end", int'(halted), 1);
    wait (xoff == 1'b0);
    repeat (2) @(negedge clk);

    // Early resume via zero-time request
    send(16'd50, a1);
    repeat (10) @(posedge clk);
    send(16'd0, a2);
    exp_q.push_back(a2 - a1);
    @(negedge clk);
    chk("R5 xoff cleared by resume", int'(xoff), 0);
    chk("R5 halted still set one edge", int'(halted), 1);
    @(negedge clk);
    chk("R5 halted cleared", int'(halted), 0);
    chk("R6 resume counted", int'(rcnt), 1);

    // Reload while paused, mid-quantum
    send(16'd4, a1);
    repeat (19) @(posedge clk);
    send(16'd6, a2);
    exp_q.push_back((a2 - a1) + 6 * TPQ);
    wait (xoff == 1'b0);
    repeat (2) @(negedge clk);

    // Shorter reload
    send(16'd9, a1);
    repeat (5) @(posedge clk);
    send(16'd1, a2);
    exp_q.push_back((a2 - a1) + 1 * TPQ);
    wait (xoff == 1'b0);
    repeat (2) @(negedge clk);

    // Zero-time while not paused
    send(16'd0, a1);
    @(negedge clk);
    chk("R6 idle resume leaves xoff low", int'(xoff), 0);
    chk("R6 idle resume counted", int'(rcnt), 2);

    // Saturation
    for (int i = 0; i < 300; i++) begin
      send(16'd0, a1);
    end
    @(negedge clk);
    chk("R7 count saturates", int'(rcnt), 255);
    chk("R10 ready held", int'(ready), 1);
    chk("R3 all episodes seen", exp_q.size(), 0);
    finish_up();
  end

endmodule